// File: doc/BRIEF.md
# Half-Duty LCD Segment Driver

This block produces the drive levels for a two-common, half-bias multiplexed LCD panel from a latched bank of display bits. Every output is a two-bit level code (low, middle or high). A free-running frame counter advances once per oscillator tick. A frame of 512 ticks is split into four equal quarters. In each quarter one common line drives high or low and the other common rests at the middle level. A segment line is lit by driving it opposite to the active common. An unlit segment follows the active common. Over a frame this leaves no net DC across any pixel.

Each segment pin owns a pair of display bits, one for each common. The lowest pins can be turned into static general-purpose ports, which follow one display bit each. The two highest pins can be handed to a key-scan circuit, in which case they carry no segment drive. Three controls take the panel down: a blank control, a sleep control and a display reset. The blank control unlights every segment. Sleep stops the frame counter and pulls all common and segment drive low, while the ports keep working. The display reset forces every drive low and returns the low pins to segment use. The display bits stay an ordinary input throughout, so the latch that feeds them can be loaded while the display reset is held.

Top module: `hduty_lcd_drv`

## Requirements
- R1: The frame counter advances by one on each clock edge where `tick_i` is 1, and it wraps after 512 ticks. Quarter q = count/128 selects the drive pattern: q0 gives COM1 high, q1 gives COM2 high, q2 gives COM1 low, and q3 gives COM2 low. The common that is not active in a quarter sits at middle. Without a tick the quarter does not change.
- R2: Segment pin n (1 to 45) reads `disp_bits_i[2n-2]` while COM1 is active and `disp_bits_i[2n-1]` while COM2 is active. If the selected bit is 1, the pin drives the opposite of the active common's level (high↔low). Otherwise it drives the same level as the active common.
- R3: While `blank_i` is 1, every pin in segment use drives the active common's level, whatever the display bits hold.
- R4: `port_sel_i` selects the static ports. 00 gives no ports, 01 gives pins 1–2, 10 gives pins 1–3 and 11 gives pins 1–4. For a port pin i, `port_o[i-1]` equals `disp_bits_i[2i-2]` and its segment code is low. Every `port_o` bit of a pin not in port use is 0.
- R5: While `sleep_i` is 1, all common and segment codes are low and the frame counter is held at 0. The ports keep following R4.
- R6: While `disp_rst_i` is 1, all common and segment codes are low, all `port_o` bits are 0 and the frame counter is held at 0. The display reset takes precedence over sleep and port selection.
- R7: `ks_sel_i[1]` is K0 and `ks_sel_i[0]` is K1. Pin 44 is a segment when K0 or K1 is 1. Pin 45 is a segment only when K0 is 1. A pin in key-scan use carries segment code low.
- R8: Level codes are 2'b00 for low, 2'b01 for middle and 2'b10 for high. Code 2'b11 never appears on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the frame counter |
| tick_i | input | 1 | Oscillator tick enable, one frame step per tick |
| disp_rst_i | input | 1 | Display reset: forces all drive low and the pins into segment use |
| sleep_i | input | 1 | Sleep: stops the counter and drives commons and segments low |
| blank_i | input | 1 | Blank all segments |
| port_sel_i | input | 2 | Number of low pins in static port use |
| ks_sel_i | input | 2 | Key-scan or segment use of pins 44 and 45 ([1]=K0, [0]=K1) |
| disp_bits_i | input | 90 | Display bits; bit 2n-2 is the COM1 bit and bit 2n-1 the COM2 bit of pin n |
| com_lvl_o | output | 4 | Level codes, COM1 in [1:0] and COM2 in [3:2] |
| seg_lvl_o | output | 90 | Level code of segment pin n in bits [2n-1:2n-2] |
| port_o | output | 4 | Static port levels for pins 1 to 4 |

## Verification
The bound assertions check several rules on every cycle. Exactly one common is away from middle while the display runs. The quarter is steady without a tick and only steps forward. Sleep and display reset pull all drive low and clear the phase. The display reset silences the ports, an unused key pin stays low, blanked segments track the active common, and no output ever shows the unused code. Only the bench's scenarios show the pairing of individual display bits with each common and the exact quarter boundaries at ticks 128, 256, 384 and 512. They also show the per-setting port map and the restart at the first quarter after sleep. These are checked against a bench model under directed edges and random data and control.

// File: rtl/hdl_lcd_pkg.sv
package hdl_lcd_pkg;

   typedef enum logic [1:0] {
      LVL_LOW  = 2'b00,
      LVL_MID  = 2'b01,
      LVL_HIGH = 2'b10
   } lvl_e;

   // Mirror a drive level about the middle rail.
   function automatic lvl_e lvl_mirror(input lvl_e l);
      case (l)
         LVL_HIGH: lvl_mirror = LVL_LOW;
         LVL_LOW:  lvl_mirror = LVL_HIGH;
         default:  lvl_mirror = LVL_MID;
      endcase
   endfunction

endpackage

// File: rtl/hdl_phase_gen.sv
module hdl_phase_gen #(
   parameter int FRAME_TICKS = 512
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       hold_i,
   input  logic       tick_i,
   output logic [1:0] quarter_o
);
   localparam int CW = $clog2(FRAME_TICKS);

   logic [CW-1:0] cnt_q;

   // Power-of-two frame: the counter wraps on its own.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         cnt_q <= '0;
      else if (hold_i)
         cnt_q <= '0;
      else if (tick_i)
         cnt_q <= cnt_q + 1'b1;
   end

   assign quarter_o = cnt_q[CW-1 -: 2];

endmodule

// File: rtl/hdl_com_drv.sv
module hdl_com_drv
   import hdl_lcd_pkg::*;
(
   input  logic [1:0] quarter_i,
   input  logic       off_i,
   output lvl_e       com1_o,
   output lvl_e       com2_o,
   output lvl_e       act_o
);
   // First half of the frame drives high, second half drives low.
   assign act_o = quarter_i[1] ? LVL_LOW : LVL_HIGH;

   always_comb begin
      if (off_i) begin
         com1_o = LVL_LOW;
         com2_o = LVL_LOW;
      end else if (!quarter_i[0]) begin
         com1_o = act_o;
         com2_o = LVL_MID;
      end else begin
         com1_o = LVL_MID;
         com2_o = act_o;
      end
   end

endmodule

// File: rtl/hdl_seg_lane.sv
module hdl_seg_lane
   import hdl_lcd_pkg::*;
(
   input  lvl_e act_i,
   input  logic com2_phase_i,
   input  logic bit_c1_i,
   input  logic bit_c2_i,
   input  logic blank_i,
   input  logic force_low_i,
   output lvl_e lvl_o
);
   logic lit;

   assign lit = (com2_phase_i ? bit_c2_i : bit_c1_i) & ~blank_i;

   always_comb begin
      if (force_low_i)
         lvl_o = LVL_LOW;
      else if (lit)
         lvl_o = lvl_mirror(act_i);
      else
         lvl_o = act_i;
   end

endmodule

// File: rtl/hduty_lcd_drv.sv
module hduty_lcd_drv
   import hdl_lcd_pkg::*;
#(
   parameter int NUM_SEG     = 45,
   parameter int NUM_PORT    = 4,
   parameter int FRAME_TICKS = 512
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 tick_i,
   input  logic                 disp_rst_i,
   input  logic                 sleep_i,
   input  logic                 blank_i,
   input  logic [1:0]           port_sel_i,
   input  logic [1:0]           ks_sel_i,
   input  logic [2*NUM_SEG-1:0] disp_bits_i,
   output logic [3:0]           com_lvl_o,
   output logic [2*NUM_SEG-1:0] seg_lvl_o,
   output logic [NUM_PORT-1:0]  port_o
);
   localparam int LW     = 2;
   localparam int KEY_A  = NUM_SEG - 2;
   localparam int KEY_B  = NUM_SEG - 1;
   localparam int KS_K0  = 1;
   localparam int KS_K1  = 0;

   // Elaboration-time parameter checks
   if (FRAME_TICKS < 8 || (FRAME_TICKS & (FRAME_TICKS - 1)) != 0) begin : g_bad_frame
      $error("FRAME_TICKS must be a power of two of at least 8");
   end
   if (NUM_PORT < 1 || NUM_PORT > 4) begin : g_bad_port
      $error("NUM_PORT must lie in 1..4");
   end
   if (NUM_SEG < NUM_PORT + 2) begin : g_bad_seg
      $error("NUM_SEG too small for ports plus key pins");
   end

   logic [1:0] quarter;
   logic       off;
   lvl_e       com1, com2, act;

   assign off = disp_rst_i | sleep_i;

   hdl_phase_gen #(.FRAME_TICKS(FRAME_TICKS)) u_phase (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .hold_i    (off),
      .tick_i    (tick_i),
      .quarter_o (quarter)
   );

   hdl_com_drv u_com (
      .quarter_i (quarter),
      .off_i     (off),
      .com1_o    (com1),
      .com2_o    (com2),
      .act_o     (act)
   );

   assign com_lvl_o = {com2, com1};

   for (genvar i = 0; i < NUM_SEG; i++) begin : g_pin
      logic port_mode;
      logic key_mode;
      lvl_e lane_lvl;

      if (i < NUM_PORT) begin : g_port
         if (i == 0) begin : g_first
            assign port_mode = ~disp_rst_i & (|port_sel_i);
         end else begin : g_rest
            assign port_mode = ~disp_rst_i & (port_sel_i >= 2'(i));
         end
         assign port_o[i] = port_mode & disp_bits_i[2*i];
      end else begin : g_noport
         assign port_mode = 1'b0;
      end

      if (i == KEY_A) begin : g_key_a
         assign key_mode = ~(ks_sel_i[KS_K0] | ks_sel_i[KS_K1]);
      end else if (i == KEY_B) begin : g_key_b
         assign key_mode = ~ks_sel_i[KS_K0];
      end else begin : g_nokey
         assign key_mode = 1'b0;
      end

      hdl_seg_lane u_lane (
         .act_i        (act),
         .com2_phase_i (quarter[0]),
         .bit_c1_i     (disp_bits_i[2*i]),
         .bit_c2_i     (disp_bits_i[2*i+1]),
         .blank_i      (blank_i),
         .force_low_i  (off | port_mode | key_mode),
         .lvl_o        (lane_lvl)
      );

      assign seg_lvl_o[LW*i +: LW] = lane_lvl;
   end

endmodule

// File: rtl/hduty_lcd_chk.sv
module hduty_lcd_chk #(
   parameter int NUM_SEG  = 45,
   parameter int NUM_PORT = 4
) (
   input logic                 clk_i,
   input logic                 rst_ni,
   input logic                 tick_i,
   input logic                 disp_rst_i,
   input logic                 sleep_i,
   input logic                 blank_i,
   input logic [1:0]           port_sel_i,
   input logic [1:0]           ks_sel_i,
   input logic [1:0]           quarter,
   input logic [3:0]           com_lvl_o,
   input logic [2*NUM_SEG-1:0] seg_lvl_o,
   input logic [NUM_PORT-1:0]  port_o
);
   logic       running;
   logic [1:0] act_lvl;
   logic       codes_ok;
   logic       mid_unlit;

   assign running = ~disp_rst_i & ~sleep_i;
   assign act_lvl = (com_lvl_o[1:0] != 2'b01) ? com_lvl_o[1:0] : com_lvl_o[3:2];

   always_comb begin
      codes_ok  = (com_lvl_o[1:0] != 2'b11) && (com_lvl_o[3:2] != 2'b11);
      mid_unlit = 1'b1;
      for (int k = 0; k < NUM_SEG; k++) begin
         if (seg_lvl_o[2*k +: 2] == 2'b11) codes_ok = 1'b0;
         if (k >= NUM_PORT && k < NUM_SEG - 2 && seg_lvl_o[2*k +: 2] != act_lvl)
            mid_unlit = 1'b0;
      end
   end

   // R8
   code_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) codes_ok);

   // R1
   one_com_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      running |-> ((com_lvl_o[1:0] == 2'b01) != (com_lvl_o[3:2] == 2'b01)));

   // R1
   quarter_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (running && !tick_i) |=> $stable(quarter));

   // R1
   quarter_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (running && $changed(quarter)) |-> (quarter == $past(quarter) + 2'd1));

   // R5
   off_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (disp_rst_i || sleep_i) |-> (com_lvl_o == '0 && seg_lvl_o == '0));

   // R5
   off_phase_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (disp_rst_i || sleep_i) |=> (quarter == 2'd0));

   // R6
   rst_port_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      disp_rst_i |-> (port_o == '0));

   // R4
   port_none_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (port_sel_i == 2'b00) |-> (port_o == '0));

   // R7
   key_pin_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ks_sel_i[1] |-> (seg_lvl_o[2*NUM_SEG-1 -: 2] == 2'b00));

   // R3
   blank_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (running && blank_i) |-> mid_unlit);

endmodule

bind hduty_lcd_drv hduty_lcd_chk #(.NUM_SEG(NUM_SEG), .NUM_PORT(NUM_PORT)) i_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .tick_i     (tick_i),
   .disp_rst_i (disp_rst_i),
   .sleep_i    (sleep_i),
   .blank_i    (blank_i),
   .port_sel_i (port_sel_i),
   .ks_sel_i   (ks_sel_i),
   .quarter    (quarter),
   .com_lvl_o  (com_lvl_o),
   .seg_lvl_o  (seg_lvl_o),
   .port_o     (port_o)
);

// File: tb/test_hduty_lcd_drv.sv
module test_hduty_lcd_drv;
   localparam int NS = 45;
   localparam int NP = 4;
   localparam int FT = 512;
   localparam int QT = FT / 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0;
   logic drst = 1'b1;
   logic slp = 1'b0;
   logic blk = 1'b0;
   logic [1:0] psel = 2'b00;
   logic [1:0] ksel = 2'b00;
   logic [2*NS-1:0] dbits = '0;
   logic [3:0] com;
   logic [2*NS-1:0] seg;
   logic [NP-1:0] prt;

   int cnt = 0;
   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   hduty_lcd_drv i_hduty_lcd_drv (
      .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .disp_rst_i(drst),
      .sleep_i(slp), .blank_i(blk), .port_sel_i(psel), .ks_sel_i(ksel),
      .disp_bits_i(dbits), .com_lvl_o(com), .seg_lvl_o(seg), .port_o(prt)
   );

   function automatic bit is_off();
      return drst || slp;
   endfunction

   function automatic bit is_port(int i);
      return !drst && i < NP && psel != 2'b00 && i <= int'(psel);
   endfunction

   function automatic logic [3:0] exp_com();
      int q = cnt / QT;
      logic [1:0] a = (q < 2) ? 2'b10 : 2'b00;
      if (is_off()) return 4'b0000;
      return (q % 2 == 0) ? {2'b01, a} : {a, 2'b01};
   endfunction

   function automatic logic [2*NS-1:0] exp_seg();
      logic [2*NS-1:0] v = '0;
      int q = cnt / QT;
      logic [1:0] a = (q < 2) ? 2'b10 : 2'b00;
      for (int i = 0; i < NS; i++) begin
         bit key = (i == NS-2 && ksel == 2'b00) || (i == NS-1 && !ksel[1]);
         bit b = (q % 2 == 1) ? dbits[2*i+1] : dbits[2*i];
         if (is_off() || is_port(i) || key) v[2*i +: 2] = 2'b00;
         else if (b && !blk) v[2*i +: 2] = (a == 2'b10) ? 2'b00 : 2'b10;
         else v[2*i +: 2] = a;
      end
      return v;
   endfunction

   function automatic logic [NP-1:0] exp_port();
      logic [NP-1:0] v = '0;
      for (int i = 0; i < NP; i++) v[i] = is_port(i) ? dbits[2*i] : 1'b0;
      return v;
   endfunction

   task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check_all(string tag);
      bit bad = 1'b0;
      #1;
      chk({tag, " com"}, 128'(com), 128'(exp_com()));
      chk({tag, " seg"}, 128'(seg), 128'(exp_seg()));
      chk({tag, " port"}, 128'(prt), 128'(exp_port()));
      for (int i = 0; i < NS; i++) if (seg[2*i +: 2] == 2'b11) bad = 1'b1;
      if (com[1:0] == 2'b11 || com[3:2] == 2'b11) bad = 1'b1;
      chk({tag, " R8 code range"}, 128'(bad), 128'(0));
   endtask

   // One clock edge so that a hold clears the counter.
   task automatic settle();
      @(negedge clk);
      if (is_off()) cnt = 0;
   endtask

   task automatic run(int n);
      if (n > 0) begin
         @(negedge clk);
         tick = 1'b1;
         repeat (n) @(negedge clk);
         tick = 1'b0;
         if (!is_off()) cnt = (cnt + n) % FT;
      end
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      settle();
      dbits = {45{2'b10}};
      psel = 2'b11;
      settle();
      check_all("R6 reset state, ports silent");
      run(37);
      check_all("R6 ticks ignored in reset");

      drst = 1'b0; psel = 2'b00; ksel = 2'b10;
      dbits = 90'h2AA_5555_0F0F_3C3C_9669_A5A5;
      settle();
      check_all("R1 start of frame q0");
      run(QT - 1);
      check_all("R2 last tick of q0");
      run(1);
      check_all("R1 boundary into q1");
      run(QT);
      check_all("R1 q2 COM1 low");
      run(QT);
      check_all("R1 q3 COM2 low");
      run(QT - 1);
      check_all("R2 last tick of q3");
      run(1);
      check_all("R1 frame wrap to q0");
      repeat (20) @(negedge clk);
      check_all("R1 hold without tick");

      blk = 1'b1;
      for (int q = 0; q < 4; q++) begin
         check_all("R3 blank");
         run(QT);
      end
      blk = 1'b0;

      for (int s = 0; s < 4; s++) begin
         psel = 2'(s);
         dbits[7:0] = 8'b0101_0101;
         settle();
         check_all("R4 port map all ones");
         dbits[7:0] = 8'b1010_0100;
         settle();
         check_all("R4 port map mixed");
      end

      run(200);
      slp = 1'b1;
      settle();
      check_all("R5 sleep low, ports live");
      dbits[7:0] = 8'b0000_0001;
      run(50);
      check_all("R5 sleep holds counter");
      slp = 1'b0;
      settle();
      check_all("R5 wake at q0");

      run(300);
      drst = 1'b1;
      dbits = ~dbits;
      settle();
      check_all("R6 reset over ports, latch loads");
      slp = 1'b1;
      settle();
      check_all("R6 reset with sleep");
      drst = 1'b0; slp = 1'b0;
      settle();
      check_all("R6 released shows new bits");

      dbits = '1;
      for (int k = 0; k < 4; k++) begin
         ksel = 2'(k);
         settle();
         check_all("R7 key pin select");
         run(QT);
         check_all("R7 key pin select next quarter");
      end

      for (int it = 0; it < 70; it++) begin
         dbits = 90'({$urandom(), $urandom(), $urandom()});
         psel  = 2'($urandom_range(0, 3));
         ksel  = 2'($urandom_range(0, 3));
         blk   = ($urandom_range(0, 5) == 0);
         slp   = ($urandom_range(0, 7) == 0);
         drst  = ($urandom_range(0, 11) == 0);
         settle();
         run($urandom_range(0, 260));
         check_all("R2 random pattern");
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule